// File: doc/BRIEF.md
# Packed Double Reciprocal Square Root Estimator

This block takes a vector of up to eight 64-bit IEEE-754 double lanes and produces, for each active lane, an estimate of one over the square root of its value. The relative error of every estimate stays below 2^-14. Special operands (zeros, infinities, negatives, NaNs, subnormals) get fixed results. A per-lane write mask, with either merging or zeroing, decides whether each lane is computed, keeps its prior destination value, or is cleared. A broadcast option feeds element 0 to every lane. A vector-length select chooses 2, 4 or 8 active lanes, and every lane above that count is forced to zero. The result does not depend on any rounding mode, and no exception flags are produced.

One operation starts when `start` is high while the unit is idle. The unit captures every operand at that edge and then handles one active lane per clock through a single shared estimator core. It pulses `done` when the whole vector is written. `result` then holds its value until the next operation is accepted.

Control is a three-state machine:
- `S_IDLE` waits for work. Transition `T_GO` (start seen) leads to `S_LANE`.
- `S_LANE` writes one lane per cycle. Transition `T_STEP` stays in `S_LANE`. Transition `T_FINISH`, taken on the last active lane, leads to `S_DONE`.
- `S_DONE` raises `done` for one cycle. Transition `T_RETIRE` returns to `S_IDLE`.

Top module: `rsq_packed_estimator`

## Requirements
- R1: After reset `busy`, `done` and `result` are all zero. When `start` is sampled high in idle, `done` is high for exactly one cycle, beginning after the N-th rising edge that follows the sampling edge. N is 2, 4 or 8 for `vlen` = 00, 01 or 10, and `vlen` = 11 is treated as 8 lanes.
- R2: When `done` is high, every 64-bit lane at or above N reads zero.
- R3: Lane j is computed when `mask_en` is 0 or `lane_mask[j]` is 1. Otherwise, with `zero_mode` = 0 it takes lane j of `prior_vec`, and with `zero_mode` = 1 it becomes zero.
- R4: With `bcast` = 1, every computed lane uses bits [63:0] of `src_vec` as its operand.
- R5: For a positive finite operand that is not an exact power covered by R6, the result is a positive normal double whose relative error against the true 1/sqrt is below 2^-14. This includes subnormal operands when `daz` = 0.
- R6: An operand that is exactly 2^(-2n) gives exactly 2^n.
- R7: +0 gives +infinity (0x7FF0000000000000), -0 gives -infinity (0xFFF0000000000000), and +infinity gives +0.
- R8: Any negative operand that is not zero and not a NaN, including -infinity and negative subnormals when `daz` = 0, gives 0xFFF8000000000000.
- R9: A NaN operand (exponent all ones, nonzero fraction) comes back with fraction bit 51 set and every other bit unchanged. A quiet NaN therefore passes through unchanged.
- R10: With `daz` = 1, a subnormal operand is treated as a zero of the same sign, giving infinity of that sign.
- R11: `start` has no effect while `busy` is high, including the `done` cycle. Between operations `result` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| src_vec | input | LANES*64 | Source lanes, lane j at bits [64j+63:64j] |
| prior_vec | input | LANES*64 | Prior destination lanes used by merge masking |
| lane_mask | input | LANES | Per-lane write mask |
| mask_en | input | 1 | 1 applies `lane_mask`, 0 computes every active lane |
| zero_mode | input | 1 | 1 clears masked-off lanes, 0 merges them from `prior_vec` |
| bcast | input | 1 | 1 feeds lane 0 of `src_vec` to every lane |
| vlen | input | 2 | Active length: 00 = 128, 01 = 256, 10/11 = 512 bits |
| daz | input | 1 | Treat subnormal operands as signed zero |
| busy | output | 1 | High from the accepting edge until the `done` cycle ends |
| done | output | 1 | One-cycle pulse when `result` is complete |
| result | output | LANES*64 | Result lanes |

## Verification
The accepting edge clears `result`. Lane k is written on the (k+1)-th edge after that, and `done` shows after the N-th edge, so the full vector is due 3, 5 or 9 edges after `start` is first seen. The bench checks `done` at every falling edge of the run against that count. It compares all lanes against its behavioural model only at the falling edge where `done` is expected, and checks the held value one cycle later. A `start` injected in mid-run and in the `done` cycle must change neither that timing nor the lanes.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    localparam int DBL_W   = 64;
    localparam int MAN_W   = 52;
    localparam int EXP_W   = 11;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LANE = 2'd1,
        S_DONE = 2'd2
    } rsq_state_e;

    // Number of lanes the length code enables, capped at the lanes built.
    function automatic int active_lanes(input logic [1:0] vl, input int max_lanes);
        int full;
        full = 2 << vl;
        return (full > max_lanes) ? max_lanes : full;
    endfunction

    // Floor square root, bit by bit.
    function automatic logic [31:0] isqrt64(input logic [63:0] v);
        logic [31:0] root;
        logic [63:0] trial;
        root = '0;
        for (int b = 31; b >= 0; b--) begin
            trial = {32'd0, root | (32'd1 << b)};
            trial = trial * trial;
            if (trial <= v) root = root | (32'd1 << b);
        end
        return root;
    endfunction

    // Knot idx of the interpolation table, value 1/sqrt(t) scaled by 2^fb.
    // idx 0..segs spans t in [1,2]; idx segs+1..2*segs+1 spans t in [2,4].
    function automatic logic [31:0] knot_value(input int idx, input int segs, input int fb);
        logic [63:0] num;
        logic [63:0] q;
        num = (idx <= segs) ? 64'(segs + idx) : 64'(2 * segs + 2 * (idx - segs - 1));
        q   = ((64'd1 << (2 * fb)) * 64'(segs)) / num;
        return isqrt64(q);
    endfunction

endpackage

// File: rtl/rsq_lzc.sv
module rsq_lzc #(
    parameter int W  = 52,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);

    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) cnt = CW'(W - 1 - i);
        end
    end

endmodule

// File: rtl/rsq_knot_interp.sv
module rsq_knot_interp import rsq_pkg::*; #(
    parameter int SEG_BITS = 6,
    parameter int FRAC_W   = 46,
    parameter int TBL_FB   = 20
) (
    input  logic                odd,
    input  logic [SEG_BITS-1:0] seg,
    input  logic [FRAC_W-1:0]   frac,
    output logic [TBL_FB:0]     est
);

    localparam int SEGS = 1 << SEG_BITS;
    localparam int NK   = 2 * SEGS + 2;
    localparam int KW   = $clog2(NK);
    localparam int KNW  = TBL_FB + 1;
    localparam int PW   = KNW + FRAC_W;

    logic [KNW-1:0] knot [NK];

    for (genvar g = 0; g < NK; g++) begin : g_knot
        assign knot[g] = KNW'(knot_value(g, SEGS, TBL_FB));
    end

    logic [KW-1:0]  k_lo;
    logic [KNW-1:0] y_lo;
    logic [KNW-1:0] y_hi;
    logic [KNW-1:0] gap;
    logic [PW-1:0]  prod;

    always_comb begin
        k_lo = odd ? (KW'(SEGS + 1) + KW'(seg)) : KW'(seg);
        y_lo = knot[k_lo];
        y_hi = knot[KW'(k_lo + 1'b1)];
        gap  = y_lo - y_hi;
        prod = PW'(gap) * PW'(frac);
        est  = y_lo - KNW'(prod >> FRAC_W);
    end

endmodule

// File: rtl/rsq_lane_core.sv
module rsq_lane_core import rsq_pkg::*; #(
    parameter int SEG_BITS = 6,
    parameter int TBL_FB   = 20
) (
    input  logic [DBL_W-1:0] x,
    input  logic             daz,
    output logic [DBL_W-1:0] y
);

    localparam int FRAC_W = MAN_W - SEG_BITS;
    localparam int LZW    = $clog2(MAN_W + 1);

    logic             sgn;
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] mf;
    assign {sgn, ex, mf} = x;

    logic ex_max, ex_zero, mf_zero;
    logic is_nan, is_inf, zero_like;
    assign ex_max    = &ex;
    assign ex_zero   = ~|ex;
    assign mf_zero   = ~|mf;
    assign is_nan    = ex_max & ~mf_zero;
    assign is_inf    = ex_max & mf_zero;
    assign zero_like = ex_zero & (mf_zero | daz);

    logic [LZW-1:0] lz;
    rsq_lzc #(.W(MAN_W), .CW(LZW)) u_lzc (
        .vec (mf),
        .cnt (lz)
    );

    logic signed [13:0] e_unb;
    logic signed [13:0] half;
    logic signed [13:0] bias_r;
    logic [MAN_W-1:0]   mn;
    logic [TBL_FB:0]    est;
    logic [MAN_W-1:0]   man_out;

    // Unbiased exponent and normalized fraction; subnormals shift by lz+1.
    always_comb begin
        if (ex_zero) begin
            e_unb = -14'sd1023 - $signed({8'd0, lz});
            mn    = mf << (lz + 6'd1);
        end else begin
            e_unb = $signed({3'b000, ex}) - 14'sd1023;
            mn    = mf;
        end
        half = e_unb >>> 1;
    end

    rsq_knot_interp #(
        .SEG_BITS (SEG_BITS),
        .FRAC_W   (FRAC_W),
        .TBL_FB   (TBL_FB)
    ) u_interp (
        .odd  (e_unb[0]),
        .seg  (mn[MAN_W-1 -: SEG_BITS]),
        .frac (mn[FRAC_W-1:0]),
        .est  (est)
    );

    always_comb begin
        bias_r = est[TBL_FB] ? 14'sd1023 : 14'sd1022;
        if (est[TBL_FB])
            man_out = {est[TBL_FB-1:0], {(MAN_W - TBL_FB){1'b0}}};
        else
            man_out = {est[TBL_FB-2:0], {(MAN_W - TBL_FB + 1){1'b0}}};

        if (is_nan)
            y = x | (64'd1 << (MAN_W - 1));
        else if (zero_like)
            y = {sgn, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
        else if (sgn)
            y = 64'hFFF8_0000_0000_0000;
        else if (is_inf)
            y = '0;
        else
            y = {1'b0, EXP_W'(bias_r - half), man_out};
    end

endmodule

// File: rtl/rsq_packed_estimator.sv
module rsq_packed_estimator import rsq_pkg::*; #(
    parameter int LANES    = 8,
    parameter int SEG_BITS = 6,
    parameter int TBL_FB   = 20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [LANES*DBL_W-1:0] src_vec,
    input  logic [LANES*DBL_W-1:0] prior_vec,
    input  logic [LANES-1:0]       lane_mask,
    input  logic                   mask_en,
    input  logic                   zero_mode,
    input  logic                   bcast,
    input  logic [1:0]             vlen,
    input  logic                   daz,
    output logic                   busy,
    output logic                   done,
    output logic [LANES*DBL_W-1:0] result
);

    localparam int VW   = LANES * DBL_W;
    localparam int IDXW = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int CNTW = $clog2(LANES + 1);

    rsq_state_e state_q, state_d;

    logic [IDXW-1:0]  idx_q;
    logic [CNTW-1:0]  nact_q;
    logic [VW-1:0]    src_q;
    logic [VW-1:0]    prior_q;
    logic [LANES-1:0] mask_q;
    logic             men_q, zmode_q, bcast_q, daz_q;
    logic [VW-1:0]    res_q;

    logic             last_lane;
    logic [DBL_W-1:0] lane_in;
    logic [DBL_W-1:0] lane_est;
    logic [DBL_W-1:0] lane_out;
    logic             lane_live;

    assign last_lane = (idx_q == IDXW'(nact_q - CNTW'(1)));

    // ---- state register ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // ---- transitions ----
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_LANE;           // T_GO
            S_LANE:  if (last_lane) state_d = S_DONE;       // T_FINISH, else T_STEP
            S_DONE:  state_d = S_IDLE;                      // T_RETIRE
            default: state_d = S_IDLE;
        endcase
    end

    // ---- shared lane datapath ----
    always_comb begin
        lane_in   = bcast_q ? src_q[DBL_W-1:0] : src_q[idx_q*DBL_W +: DBL_W];
        lane_live = ~men_q | mask_q[idx_q];
        if (lane_live)
            lane_out = lane_est;
        else if (zmode_q)
            lane_out = '0;
        else
            lane_out = prior_q[idx_q*DBL_W +: DBL_W];
    end

    rsq_lane_core #(
        .SEG_BITS (SEG_BITS),
        .TBL_FB   (TBL_FB)
    ) u_core (
        .x   (lane_in),
        .daz (daz_q),
        .y   (lane_est)
    );

    // ---- operand capture and result accumulation ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            nact_q  <= '0;
            src_q   <= '0;
            prior_q <= '0;
            mask_q  <= '0;
            men_q   <= 1'b0;
            zmode_q <= 1'b0;
            bcast_q <= 1'b0;
            daz_q   <= 1'b0;
            res_q   <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        idx_q   <= '0;
                        nact_q  <= CNTW'(active_lanes(vlen, LANES));
                        src_q   <= src_vec;
                        prior_q <= prior_vec;
                        mask_q  <= lane_mask;
                        men_q   <= mask_en;
                        zmode_q <= zero_mode;
                        bcast_q <= bcast;
                        daz_q   <= daz;
                        res_q   <= '0;
                    end
                end
                S_LANE: begin
                    res_q[idx_q*DBL_W +: DBL_W] <= lane_out;
                    idx_q <= idx_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // ---- outputs ----
    always_comb begin
        busy   = (state_q != S_IDLE);
        done   = (state_q == S_DONE);
        result = res_q;
    end

endmodule

// File: rtl/rsq_check.sv
module rsq_check #(
    parameter int LANES = 8,
    parameter int CNTW  = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                busy,
    input logic                done,
    input logic [LANES*64-1:0] result,
    input logic [CNTW-1:0]     nact
);

    localparam int SW = CNTW + 1;

    logic [SW-1:0] since_go;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_go <= '0;
        else if (!busy && start) since_go <= SW'(1);
        else if (busy)           since_go <= since_go + SW'(1);
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done) else $error("done longer than one cycle"); // R1

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) done |-> (since_go == ({1'b0, nact} + SW'(1)))) else $error("done at wrong cycle"); // R1

    AST_GO_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (!busy && start) |=> busy) else $error("start not accepted"); // R1

    AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n) (busy && start) |=> $stable(nact)) else $error("start taken while busy"); // R11

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> $stable(result)) else $error("result moved while idle"); // R11

    for (genvar g = 0; g < LANES; g++) begin : g_upper
        AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (done && (CNTW'(g) >= nact)) |-> (result[g*64 +: 64] == 64'd0)) else $error("upper lane not clear"); // R2
    end

endmodule

bind rsq_packed_estimator rsq_check #(
    .LANES (LANES),
    .CNTW  ($clog2(LANES + 1))
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result),
    .nact   (nact_q)
);

// File: tb/sim_rsq_packed_estimator.sv
module sim_rsq_packed_estimator;

    logic         clk       = 1'b0;
    logic         rst_n     = 1'b0;
    logic         start     = 1'b0;
    logic [511:0] src_vec   = '0;
    logic [511:0] prior_vec = '0;
    logic [7:0]   lane_mask = '0;
    logic         mask_en   = 1'b0;
    logic         zero_mode = 1'b0;
    logic         bcast     = 1'b0;
    logic [1:0]   vlen      = 2'b10;
    logic         daz       = 1'b0;
    logic         busy, done;
    logic [511:0] result;

    int n_chk = 0;
    int n_err = 0;

    logic [63:0] sv [8];
    logic [63:0] pv [8];

    always #4 clk = ~clk;

    rsq_packed_estimator u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .src_vec(src_vec),
        .prior_vec(prior_vec), .lane_mask(lane_mask), .mask_en(mask_en),
        .zero_mode(zero_mode), .bcast(bcast), .vlen(vlen), .daz(daz),
        .busy(busy), .done(done), .result(result)
    );

    task automatic chk_eq(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Behavioural model of one computed lane.
    task automatic lane_ref(input logic [63:0] x, input logic d,
                            output logic [63:0] e, output bit apx, output string tag);
        logic       s;
        logic [10:0] ex;
        logic [51:0] mf;
        {s, ex, mf} = x;
        apx = 1'b0;
        e   = '0;
        if (ex == 11'h7FF && mf != 0) begin
            e = x | (64'd1 << 51); tag = "R9";
        end else if (ex == 0 && (mf == 0 || d)) begin
            e = {s, 11'h7FF, 52'd0}; tag = (mf == 0) ? "R7" : "R10";
        end else if (s) begin
            e = 64'hFFF8000000000000; tag = "R8";
        end else if (ex == 11'h7FF) begin
            e = 64'd0; tag = "R7";
        end else if (mf == 0 && ex[0]) begin
            e = {1'b0, 11'((3069 - int'(ex)) / 2), 52'd0}; tag = "R6";
        end else begin
            apx = 1'b1; tag = "R5";
        end
    endtask

    task automatic chk_lane(input string tag, input logic [63:0] x, input logic [63:0] got,
                            input bit apx, input logic [63:0] e);
        real xr, rv, gr, rel;
        if (!apx) begin
            chk_eq(tag, got, e);
        end else begin
            xr  = $bitstoreal(x);
            rv  = 1.0 / $sqrt(xr);
            gr  = $bitstoreal(got);
            rel = (gr - rv) / rv;
            if (rel < 0.0) rel = -rel;
            n_chk++;
            if (got[63] || got[62:52] == 11'd0 || got[62:52] == 11'h7FF || rel >= 1.0 / 16384.0) begin
                n_err++;
                $display("FAIL %s: x %h got %h expected near %h", tag, x, got, $realtobits(rv));
            end
        end
    endtask

    task automatic run_op(input logic [7:0] m, input logic me, input logic zm, input logic bc,
                          input logic [1:0] vl, input logic d, input bit poke);
        int n;
        logic [511:0] s, p, hold;
        n = (vl == 2'b00) ? 2 : (vl == 2'b01) ? 4 : 8;
        for (int j = 0; j < 8; j++) begin
            s[j*64 +: 64] = sv[j];
            p[j*64 +: 64] = pv[j];
        end
        @(negedge clk);
        src_vec = s; prior_vec = p; lane_mask = m; mask_en = me;
        zero_mode = zm; bcast = bc; vlen = vl; daz = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= n; k++) begin
            chk_eq("R1 done timing", {63'd0, done}, {63'd0, (k == n)});
            if (poke && k == 1) begin
                start = 1'b1; src_vec = ~s; vlen = 2'b00; bcast = ~bc;
            end
            if (poke && k == 2) start = 1'b0;
            if (poke && k == n) start = 1'b1;
            if (k < n) @(negedge clk);
        end
        for (int j = 0; j < 8; j++) begin
            logic [63:0] got, x, e;
            bit apx;
            string tag;
            got = result[j*64 +: 64];
            if (j >= n) begin
                chk_eq("R2 upper lane", got, 64'd0);
            end else if (me && !m[j]) begin
                chk_eq(zm ? "R3 zeroing" : "R3 merge", got, zm ? 64'd0 : p[j*64 +: 64]);
            end else begin
                x = bc ? s[63:0] : s[j*64 +: 64];
                lane_ref(x, d, e, apx, tag);
                if (bc) tag = {tag, " R4"};
                if (poke) tag = {tag, " R11"};
                chk_lane(tag, x, got, apx, e);
            end
        end
        hold = result;
        @(negedge clk);
        start = 1'b0;
        chk_eq("R1 done pulse", {63'd0, done}, 64'd0);
        chk_eq("R11 idle after op", {63'd0, busy}, 64'd0);
        for (int j = 0; j < 8; j++) chk_eq("R11 hold", result[j*64 +: 64], hold[j*64 +: 64]);
    endtask

    initial begin
        #1200000;
        n_err++;
        $display("FAIL R1: watchdog expired, got hung run expected done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R1 reset busy", {63'd0, busy}, 64'd0);
        chk_eq("R1 reset done", {63'd0, done}, 64'd0);
        for (int j = 0; j < 8; j++) chk_eq("R1 reset result", result[j*64 +: 64], 64'd0);

        // Ordinary values and exact powers (R5, R6)
        sv[0] = $realtobits(1.0);    sv[1] = $realtobits(4.0);
        sv[2] = $realtobits(0.25);   sv[3] = $realtobits(2.0);
        sv[4] = $realtobits(3.0);    sv[5] = $realtobits(1.0e-300);
        sv[6] = $realtobits(1.0e300); sv[7] = $realtobits(7.5);
        for (int j = 0; j < 8; j++) pv[j] = 64'h1111_0000_0000_0000 + 64'(j);
        run_op(8'h00, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0);

        // Special operands without flush (R7, R8, R9, R5 subnormal)
        sv[0] = 64'h0000000000000000; sv[1] = 64'h8000000000000000;
        sv[2] = 64'h7FF0000000000000; sv[3] = 64'hFFF0000000000000;
        sv[4] = $realtobits(-2.0);    sv[5] = 64'h7FF0000000000001;
        sv[6] = 64'hFFF8000000000123; sv[7] = 64'h0000000000000001;
        run_op(8'h00, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0);

        // Subnormals flushed (R10), negative subnormal without flush (R8)
        sv[0] = 64'h0000000000000001; sv[1] = 64'h800000000000000F;
        sv[2] = 64'h000FFFFFFFFFFFFF; sv[3] = $realtobits(9.0);
        sv[4] = 64'h7FF4000000000000; sv[5] = 64'h0000000000000000;
        sv[6] = 64'h8000000000000007; sv[7] = 64'h0008000000000000;
        run_op(8'h00, 1'b0, 1'b0, 1'b0, 2'b10, 1'b1, 1'b0);
        run_op(8'h00, 1'b0, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0);

        // Merge masking at 256 bits (R3, R2)
        for (int j = 0; j < 8; j++) begin
            sv[j] = $realtobits(1.5 + 3.0 * j);
            pv[j] = 64'hA5A5_0000_0000_0000 | 64'(j);
        end
        run_op(8'h05, 1'b1, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0);

        // Zeroing masking at 128 bits (R3, R2)
        run_op(8'h02, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0);

        // Broadcast of element 0 with merge (R4, R6)
        sv[0] = $realtobits(1.0 / 1048576.0);
        run_op(8'hF3, 1'b1, 1'b0, 1'b1, 2'b10, 1'b0, 1'b0);
        sv[0] = $realtobits(5.0);
        run_op(8'h00, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0, 1'b0);

        // Exact powers across the range, length code 11, starts while busy (R6, R1, R11)
        sv[0] = $realtobits(2.0 ** 1000.0); sv[1] = $realtobits(2.0 ** 200.0);
        sv[2] = $realtobits(2.0 ** 2.0);    sv[3] = $realtobits(1.0);
        sv[4] = $realtobits(2.0 ** -2.0);   sv[5] = $realtobits(2.0 ** -14.0);
        sv[6] = $realtobits(2.0 ** -200.0); sv[7] = $realtobits(2.0 ** -1022.0);
        run_op(8'h00, 1'b0, 1'b0, 1'b0, 2'b11, 1'b0, 1'b1);
        run_op(8'h00, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1);

        // Sweep of positive normals and subnormals, mixed controls (R5, R3, R2, R10)
        for (int t = 0; t < 30; t++) begin
            for (int j = 0; j < 8; j++) begin
                sv[j] = {1'b0, 11'($urandom_range(0, 2046)), 20'($urandom), 32'($urandom)};
                if (t % 5 == 0 && j < 3) sv[j][62:52] = 11'd0;
                pv[j] = {32'($urandom), 32'($urandom)};
            end
            run_op(8'($urandom), 1'(t % 3 == 0), 1'(t % 2), 1'(t % 7 == 0),
                   2'(t % 4), 1'(t % 5 == 0), 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule